// File: doc/BRIEF.md
# Multimode Counter Shift Register

A four-bit register that acts either as a modulo-16 up/down counter or as a bidirectional shift register. A three-bit mode select picks one of eight synchronous modes, applied on the rising clock edge: LOAD (000), INVERT (001), SHIFT_LO (010), SHIFT_HI (011), DOWN (100), CLEAR (101), UP (110) and HOLD (111). The block has no sequencing state. Every clock takes the register from its current value to the value that the selected mode gives, and the mode itself is taken fresh from the select input each cycle. An active-high asynchronous reset overrides everything and forces the register to zero at once.

Two active-low enables gate counting. `cnt_en_n` is local to the stage. `chain_en_n` is the trickle enable, and in SHIFT_HI it is also the serial input. A separate serial input, `ser_msb_in`, feeds SHIFT_LO. The active-low terminal output `term_n` changes meaning with the mode. In UP and DOWN it flags the terminal count, in the two shift modes it carries the top bit, and in the other modes it is fixed. Wiring `term_n` of one stage to `chain_en_n` of the next stage builds wider counters and shift chains.

Top module: `mcsr_top`

## Requirements
- R1: In LOAD (sel=000), the rising edge copies `preset` into `q`. Bit 0 of `preset` goes to `q[0]`.
- R2: In INVERT (sel=001), the rising edge replaces every bit of `q` with its complement.
- R3: In SHIFT_LO (sel=010), the rising edge moves each bit one place toward `q[0]`: `q[i]` takes `q[i+1]`, and `q[3]` takes `ser_msb_in`.
- R4: In SHIFT_HI (sel=011), the rising edge moves each bit one place toward `q[3]`: `q[i]` takes `q[i-1]`, and `q[0]` takes `chain_en_n`.
- R5: In UP (sel=110), with `cnt_en_n` and `chain_en_n` both low, the rising edge adds one modulo 16 (15 wraps to 0). `q[3]` is the most significant bit.
- R6: In DOWN (sel=100), with both enables low, the rising edge subtracts one modulo 16 (0 wraps to 15).
- R7: In UP or DOWN, `q` keeps its value if either enable is high.
- R8: CLEAR (sel=101) loads 0000. HOLD (sel=111) keeps `q`. Neither mode looks at the enables.
- R9: In UP, `term_n` is low exactly when `chain_en_n` is low and `q`=1111. In DOWN, `term_n` is low exactly when `chain_en_n` is low and `q`=0000. Otherwise `term_n` is high in these two modes.
- R10: `term_n` equals `q[3]` in both shift modes. It is low in LOAD and INVERT and high in CLEAR and HOLD.
- R11: While `mrst` is high, `q` is 0000 without waiting for a clock edge, whatever the other inputs are.
- R12: `q_n` is always the bitwise complement of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mrst | input | 1 | Asynchronous reset, active high, clears the register |
| sel | input | 3 | Mode select |
| cnt_en_n | input | 1 | Local count enable, active low |
| chain_en_n | input | 1 | Trickle count enable, active low; serial input in SHIFT_HI |
| ser_msb_in | input | 1 | Serial input into the top bit in SHIFT_LO |
| preset | input | 4 | Parallel data for LOAD |
| q | output | 4 | Register value |
| q_n | output | 4 | Complement of the register value |
| term_n | output | 1 | Terminal-count / chaining output, meaning set by mode |

## Verification
The clocked properties assume that `sel`, the enables and the serial inputs are known and settled at each rising edge. They also assume that `mrst` does not change exactly on a clock edge, so each edge sees one defined mode and one defined reset level. The stimulus meets these assumptions by changing every input on the falling edge, and it raises and lowers `mrst` either on a falling edge or part way through a cycle. The cascade of two stages takes the upper stage's trickle enable directly from the lower stage's combinational `term_n`, which settles well before the next rising edge.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    // Mode codes, decoded from the select input each cycle.
    typedef enum logic [2:0] {
        MODE_LOAD     = 3'b000,
        MODE_INVERT   = 3'b001,
        MODE_SHIFT_LO = 3'b010,
        MODE_SHIFT_HI = 3'b011,
        MODE_DOWN     = 3'b100,
        MODE_CLEAR    = 3'b101,
        MODE_UP       = 3'b110,
        MODE_HOLD     = 3'b111
    } mode_e;

endpackage

// File: rtl/mcsr_mode_decode.sv
module mcsr_mode_decode
    import mcsr_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       cnt_en_n,
    input  logic       chain_en_n,
    output mode_e      mode,
    output logic       count_go
);

    always_comb begin
        mode     = mode_e'(sel);
        // counting needs both active-low enables asserted
        count_go = ~cnt_en_n & ~chain_en_n;
    end

endmodule

// File: rtl/mcsr_next.sv
module mcsr_next
    import mcsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mode_e            mode,
    input  logic             count_go,
    input  logic             ser_lo_src,
    input  logic             ser_hi_src,
    input  logic [WIDTH-1:0] preset,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (mode)
            MODE_LOAD:     nxt = preset;
            MODE_INVERT:   nxt = ~cur;
            MODE_SHIFT_LO: nxt = {ser_lo_src, cur[WIDTH-1:1]};
            MODE_SHIFT_HI: nxt = {cur[WIDTH-2:0], ser_hi_src};
            MODE_DOWN:     nxt = count_go ? cur - ONE : cur;
            MODE_CLEAR:    nxt = '0;
            MODE_UP:       nxt = count_go ? cur + ONE : cur;
            MODE_HOLD:     nxt = cur;
        endcase
    end

endmodule

// File: rtl/mcsr_term.sv
module mcsr_term
    import mcsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mode_e            mode,
    input  logic             chain_en_n,
    input  logic [WIDTH-1:0] cur,
    output logic             term_n
);

    logic at_top;
    logic at_bottom;

    always_comb begin
        at_top    = &cur;
        at_bottom = ~|cur;
        unique case (mode)
            MODE_LOAD,
            MODE_INVERT:   term_n = 1'b0;
            MODE_SHIFT_LO,
            MODE_SHIFT_HI: term_n = cur[WIDTH-1];
            MODE_DOWN:     term_n = ~(~chain_en_n & at_bottom);
            MODE_UP:       term_n = ~(~chain_en_n & at_top);
            MODE_CLEAR,
            MODE_HOLD:     term_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/mcsr_top.sv
module mcsr_top
    import mcsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic [2:0]       sel,
    input  logic             cnt_en_n,
    input  logic             chain_en_n,
    input  logic             ser_msb_in,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_n,
    output logic             term_n
);

    mode_e            mode;
    logic             count_go;
    logic [WIDTH-1:0] q_nxt;
    logic [WIDTH-1:0] q_reg;

    mcsr_mode_decode u_decode (
        .sel        (sel),
        .cnt_en_n   (cnt_en_n),
        .chain_en_n (chain_en_n),
        .mode       (mode),
        .count_go   (count_go)
    );

    mcsr_next #(.WIDTH(WIDTH)) u_next (
        .mode       (mode),
        .count_go   (count_go),
        .ser_lo_src (ser_msb_in),
        .ser_hi_src (chain_en_n),
        .preset     (preset),
        .cur        (q_reg),
        .nxt        (q_nxt)
    );

    mcsr_term #(.WIDTH(WIDTH)) u_term (
        .mode       (mode),
        .chain_en_n (chain_en_n),
        .cur        (q_reg),
        .term_n     (term_n)
    );

    // state register, asynchronous clear
    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) q_reg <= '0;
        else      q_reg <= q_nxt;
    end

    // outputs
    always_comb begin
        q   = q_reg;
        q_n = ~q_reg;
    end

    p_load_r1: assert property (@(posedge clk) disable iff (mrst)
        (mode == MODE_LOAD) |=> (q == $past(preset)));

    p_invert_r2: assert property (@(posedge clk) disable iff (mrst)
        (mode == MODE_INVERT) |=> (q == ~$past(q)));

    p_shift_lo_r3: assert property (@(posedge clk) disable iff (mrst)
        (mode == MODE_SHIFT_LO) |=> (q == {$past(ser_msb_in), $past(q[WIDTH-1:1])}));

    p_shift_hi_r4: assert property (@(posedge clk) disable iff (mrst)
        (mode == MODE_SHIFT_HI) |=> (q == {$past(q[WIDTH-2:0]), $past(chain_en_n)}));

    p_count_up_r5: assert property (@(posedge clk) disable iff (mrst)
        (mode == MODE_UP && !cnt_en_n && !chain_en_n) |=> (q == WIDTH'($past(q) + 1'b1)));

    p_count_down_r6: assert property (@(posedge clk) disable iff (mrst)
        (mode == MODE_DOWN && !cnt_en_n && !chain_en_n) |=> (q == WIDTH'($past(q) - 1'b1)));

    p_count_gated_r7: assert property (@(posedge clk) disable iff (mrst)
        ((mode == MODE_UP || mode == MODE_DOWN) && (cnt_en_n || chain_en_n)) |=> $stable(q));

    p_clear_r8: assert property (@(posedge clk) disable iff (mrst)
        (mode == MODE_CLEAR) |=> (q == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (mrst)
        (mode == MODE_HOLD) |=> $stable(q));

    p_term_shift_r10: assert property (@(posedge clk) disable iff (mrst)
        (mode == MODE_SHIFT_LO || mode == MODE_SHIFT_HI) |-> (term_n == q[WIDTH-1]));

    p_reset_clears_r11: assert property (@(posedge clk)
        mrst |-> (q == '0));

    p_complement_r12: assert property (@(posedge clk)
        (q ^ q_n) == '1);

endmodule

// File: tb/mcsr_top_bench.sv
`timescale 1ns/1ps
module mcsr_top_bench;

    logic       clk = 1'b0;
    logic       mrst = 1'b1;
    logic [2:0] sel = 3'b111;
    logic       cnt_en_n = 1'b1;
    logic       chain_en_n = 1'b1;
    logic       ser_msb_in = 1'b0;
    logic [3:0] preset = 4'h0;
    logic [3:0] q, q_n;
    logic       term_n;

    // cascade stimulus and outputs
    logic [2:0] c_sel = 3'b111;
    logic [3:0] lo_q, lo_qn, hi_q, hi_qn;
    logic       lo_term, hi_term;

    int total = 0;
    int fails = 0;
    int ref_q = 0;

    always #2.5 clk = ~clk;

    mcsr_top u_mcsr_top (
        .clk(clk), .mrst(mrst), .sel(sel), .cnt_en_n(cnt_en_n),
        .chain_en_n(chain_en_n), .ser_msb_in(ser_msb_in), .preset(preset),
        .q(q), .q_n(q_n), .term_n(term_n)
    );

    mcsr_top u_cas_lo (
        .clk(clk), .mrst(mrst), .sel(c_sel), .cnt_en_n(1'b0),
        .chain_en_n(1'b0), .ser_msb_in(1'b0), .preset(4'h0),
        .q(lo_q), .q_n(lo_qn), .term_n(lo_term)
    );

    mcsr_top u_cas_hi (
        .clk(clk), .mrst(mrst), .sel(c_sel), .cnt_en_n(1'b0),
        .chain_en_n(lo_term), .ser_msb_in(1'b0), .preset(4'h0),
        .q(hi_q), .q_n(hi_qn), .term_n(hi_term)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_term(int s, int cet, int v);
        case (s)
            0, 1:    return 0;
            2, 3:    return (v >> 3) & 1;
            4:       return (cet == 0 && v == 0) ? 0 : 1;
            6:       return (cet == 0 && v == 15) ? 0 : 1;
            default: return 1;
        endcase
    endfunction

    function automatic int model_next(int s, int cep, int cet, int d3, int p, int v);
        case (s)
            0: return p;
            1: return 15 - v;
            2: return (v / 2) + 8 * d3;
            3: return ((v * 2) % 16) + cet;
            4: return (cep == 0 && cet == 0) ? (v + 15) % 16 : v;
            5: return 0;
            6: return (cep == 0 && cet == 0) ? (v + 1) % 16 : v;
            default: return v;
        endcase
    endfunction

    function automatic string q_tag(int s, int cep, int cet);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return (cep == 0 && cet == 0) ? "R6" : "R7";
            6: return (cep == 0 && cet == 0) ? "R5" : "R7";
            default: return "R8";
        endcase
    endfunction

    // One clock of the main instance: drive, check term_n, clock, check q and q_n.
    task automatic step(input int s, input int cep, input int cet, input int d3, input int p);
        @(negedge clk);
        sel = 3'(s); cnt_en_n = cep[0]; chain_en_n = cet[0];
        ser_msb_in = d3[0]; preset = 4'(p);
        #1;
        chk((s == 4 || s == 6) ? "R9 term" : "R10 term", int'(term_n), model_term(s, cet, ref_q));
        @(posedge clk);
        ref_q = model_next(s, cep, cet, d3, p, ref_q);
        #1;
        chk(q_tag(s, cep, cet), int'(q), ref_q);
        chk("R12 complement", int'(q_n), 15 - ref_q);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset value", int'(q), 0);
        chk("R12 reset complement", int'(q_n), 15);
        mrst = 1'b0;
        ref_q = 0;

        // parallel load, invert, shifts
        step(0, 1, 1, 0, 4'b1010);
        step(1, 1, 1, 0, 0);
        step(2, 1, 1, 1, 0);
        step(2, 0, 0, 0, 0);
        step(3, 1, 0, 0, 0);
        step(3, 1, 1, 0, 0);
        step(3, 0, 1, 1, 0);
        step(2, 1, 1, 1, 0);

        // clear and hold ignore enables
        step(0, 1, 1, 0, 4'b0110);
        step(7, 0, 0, 1, 4'b1111);
        step(7, 1, 0, 0, 4'b0000);
        step(5, 1, 1, 1, 4'b1111);
        step(5, 0, 0, 0, 4'b1111);

        // count up to terminal value and wrap
        step(0, 1, 1, 0, 14);
        step(6, 0, 0, 0, 0);
        step(6, 1, 0, 0, 0);
        step(6, 0, 1, 0, 0);
        step(6, 1, 1, 0, 0);
        step(6, 0, 0, 0, 0);
        step(6, 0, 0, 0, 0);

        // count down to zero and wrap
        step(0, 1, 1, 0, 1);
        step(4, 0, 0, 0, 0);
        step(4, 1, 0, 0, 0);
        step(4, 0, 1, 0, 0);
        step(4, 0, 0, 0, 0);
        step(4, 0, 0, 0, 0);

        // mixed stimulus over every mode
        for (int i = 0; i < 300; i++) begin
            int r;
            r = int'($urandom);
            step(r & 7, (r >> 3) & 1, (r >> 4) & 1, (r >> 5) & 1, (r >> 6) & 15);
        end

        // asynchronous reset in mid-cycle
        step(0, 1, 1, 0, 4'b1011);
        @(negedge clk);
        sel = 3'b110; cnt_en_n = 1'b0; chain_en_n = 1'b0;
        #1 mrst = 1'b1;
        #0.5;
        chk("R11 async clear", int'(q), 0);
        @(posedge clk); #1;
        chk("R11 clock ignored", int'(q), 0);
        chk("R9 term during reset", int'(term_n), 1);
        @(negedge clk);
        mrst = 1'b0;
        ref_q = 0;

        // two-stage cascade, up through 0..255 and back down
        c_sel = 3'b110;
        for (int i = 1; i <= 256; i++) begin
            @(posedge clk); #1;
            chk("R5 R9 cascade up", int'({hi_q, lo_q}), i % 256);
        end
        @(negedge clk);
        c_sel = 3'b100;
        for (int i = 1; i <= 256; i++) begin
            @(posedge clk); #1;
            chk("R6 R9 cascade down", int'({hi_q, lo_q}), (256 - i) % 256);
        end
        @(negedge clk);
        c_sel = 3'b111;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

endmodule